// File: doc/BRIEF.md
# Multi-Mode Bit Clock Recovery Loop

This block rebuilds a bit clock from a hard-limited serial stream. The input is looked at on every tick of an oversampling enable that runs at 64 ticks per bit. A 6-bit phase counter marks out one bit per lap. Each input transition is timed against the point where the loop expects a bit boundary, which is counter value 0. The signed timing errors of two transitions in a row are combined into one phase correction. How far that correction may move the counter depends on the loop mode.

Two control inputs and an internal bit timer choose the mode. Raising `acq_i` gives a wide loop that pulls in within a couple of transitions. Dropping it, while `track_i` stays high, gives a medium loop for 30 bit periods and then a narrow loop. Pulling `track_i` low opens the loop so the clock freewheels through a fade. The block outputs the recovered clock, the data bit taken at mid-bit and a per-transition timing-quality flag with a strobe. The data bit is registered one bit ahead of the clock edge that should capture it.

Top module: `bit_clock_recovery`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the phase counter and bit timer and drives `rclk_o`, `rdata_o`, `qual_good_o` and `qual_stb_o` to 0.
- R2: With `acq_i`=0 and `track_i`=0 (hold), input transitions apply no correction. The phase counter advances by exactly 1 per `os_en_i` tick modulo 64, and `rclk_o` is high exactly while the counter is 32..63.
- R3: A transition is detected on an `os_en_i` tick where `din_i` differs from its value at the previous tick. Its phase error is the current counter value c folded to c for c<32 and c-64 otherwise.
- R4: While `acq_i`=1, every second transition moves the counter by the floor of half the sum of the two errors. On the tick of that transition the counter becomes c+1-adj modulo 64. A clean stream at any starting offset is locked within 8 transitions, after which every transition is graded good.
- R5: With `acq_i`=0, `track_i`=1 and fewer than 30 sample events since `acq_i` was last high, the pair correction is the error sum clamped to the range -4..+4.
- R6: With `acq_i`=0, `track_i`=1 and at least 30 sample events since `acq_i` was last high, the pair correction is the error sum clamped to the range -1..+1.
- R7: The bit timer is cleared in every cycle with `acq_i`=1. Otherwise it counts sample events and saturates at 30, whatever the value of `track_i`. Pairing restarts in hold mode.
- R8: A sample event is an `os_en_i` tick with the counter at 32. There `rdata_o` takes `din_i`, and it holds its value at every other time.
- R9: `qual_stb_o` is high for exactly the one clock cycle after each transition tick, in every mode. At that point `qual_good_o` shows whether the magnitude of the transition's phase error is at most 8, and it keeps that value until the next transition.
- R10: In cycles with `os_en_i`=0 no state changes, whatever the value of `din_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| os_en_i | input | 1 | Oversampling enable, 64 ticks per bit |
| din_i | input | 1 | Hard-limited serial input |
| acq_i | input | 1 | Wide-band acquire request |
| track_i | input | 1 | 1 closes the loop, 0 holds (freewheel) |
| rclk_o | output | 1 | Recovered bit clock, rises at mid-bit |
| rdata_o | output | 1 | Data bit sampled at mid-bit |
| qual_good_o | output | 1 | Timing grade of the last transition |
| qual_stb_o | output | 1 | One-cycle strobe per graded transition |

## Verification
The hardest situation to reach from the ports is the hand-over from the medium to the narrow clamp while the loop still has phase error left to remove. The timer is hidden, and a locked loop produces no error for the clamp to act on. The stimulus releases acquire and at once shifts the transmitter phase by 12 ticks. A second shift of 6 ticks follows after more than 30 bits, so that both clamps are seen limiting real corrections. Hold and enable-gap windows then toggle the input while the loop must ignore it.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef enum logic [1:0] {
    MODE_ACQ  = 2'd0,
    MODE_MED  = 2'd1,
    MODE_NAR  = 2'd2,
    MODE_HOLD = 2'd3
  } bcr_mode_e;

  // signed phase error of a counter value: early half positive, late half negative
  function automatic int fold_phase(int cnt, int ticks);
    return (cnt < ticks / 2) ? cnt : cnt - ticks;
  endfunction

  function automatic int clamp_mag(int v, int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // arithmetic shift rounds toward minus infinity
  function automatic int half_floor(int v);
    return v >>> 1;
  endfunction

  function automatic int abs_i(int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/bcr_xing_det.sv
module bcr_xing_det (
  input  logic clk_i,
  input  logic rst_i,
  input  logic os_en_i,
  input  logic din_i,
  output logic xing_o
);
  logic din_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        din_q <= 1'b0;
    else if (os_en_i) din_q <= din_i;
  end

  assign xing_o = os_en_i && (din_i != din_q);
endmodule

// File: rtl/bcr_mode_ctrl.sv
module bcr_mode_ctrl
  import bcr_pkg::*;
#(
  parameter int MED_BITS = 30,
  localparam int TMR_W = $clog2(MED_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             acq_i,
  input  logic             track_i,
  input  logic             sample_ev_i,
  output logic [TMR_W-1:0] tmr_o,
  output bcr_mode_e        mode_o
);
  logic [TMR_W-1:0] tmr;
  logic             tmr_sat;

  assign tmr_sat = (tmr >= TMR_W'(MED_BITS));

  always_ff @(posedge clk_i) begin
    if (rst_i)                        tmr <= '0;
    else if (acq_i)                   tmr <= '0;
    else if (sample_ev_i && !tmr_sat) tmr <= tmr + TMR_W'(1);
  end

  always_comb begin
    if (acq_i)         mode_o = MODE_ACQ;
    else if (!track_i) mode_o = MODE_HOLD;
    else if (!tmr_sat) mode_o = MODE_MED;
    else               mode_o = MODE_NAR;
  end

  assign tmr_o = tmr;
endmodule

// File: rtl/bcr_phase_loop.sv
module bcr_phase_loop
  import bcr_pkg::*;
#(
  parameter int OS_TICKS = 64,
  parameter int MED_LIM  = 4,
  parameter int NAR_LIM  = 1,
  localparam int CNT_W = $clog2(OS_TICKS),
  localparam int ERR_W = CNT_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    os_en_i,
  input  logic                    xing_i,
  input  bcr_mode_e               mode_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic signed [ERR_W-1:0] adj_o,
  output logic                    pair_done_o
);
  logic [CNT_W-1:0]        cnt;
  logic                    armed;
  logic signed [ERR_W-1:0] err1;
  int                      pair_sum;
  int                      adj_i;

  assign err_o       = ERR_W'(fold_phase(int'(cnt), OS_TICKS));
  assign pair_sum    = int'(err1) + int'(err_o);
  assign pair_done_o = xing_i && armed && (mode_i != MODE_HOLD);

  always_comb begin
    adj_i = 0;
    if (pair_done_o) begin
      case (mode_i)
        MODE_ACQ: adj_i = half_floor(pair_sum);
        MODE_MED: adj_i = clamp_mag(pair_sum, MED_LIM);
        MODE_NAR: adj_i = clamp_mag(pair_sum, NAR_LIM);
        default:  adj_i = 0;
      endcase
    end
  end
  assign adj_o = ERR_W'(adj_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed <= 1'b0;
      err1  <= '0;
    end else if (mode_i == MODE_HOLD) begin
      armed <= 1'b0;
    end else if (xing_i) begin
      armed <= !armed;
      if (!armed) err1 <= err_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        cnt <= '0;
    else if (os_en_i) cnt <= CNT_W'(int'(cnt) + 1 - int'(adj_o));
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery
  import bcr_pkg::*;
#(
  parameter int OS_TICKS = 64,
  parameter int MED_BITS = 30,
  parameter int MED_LIM  = 4,
  parameter int NAR_LIM  = 1,
  parameter int GOOD_TOL = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic os_en_i,
  input  logic din_i,
  input  logic acq_i,
  input  logic track_i,
  output logic rclk_o,
  output logic rdata_o,
  output logic qual_good_o,
  output logic qual_stb_o
);
  localparam int CNT_W = $clog2(OS_TICKS);
  localparam int ERR_W = CNT_W + 2;
  localparam int HALF  = OS_TICKS / 2;
  localparam int TMR_W = $clog2(MED_BITS + 1);

  logic                    xing;
  logic                    sample_ev;
  logic                    pair_done;
  logic [TMR_W-1:0]        tmr;
  logic [CNT_W-1:0]        cnt;
  logic signed [ERR_W-1:0] xing_err;
  logic signed [ERR_W-1:0] adj;
  bcr_mode_e               mode;

  bcr_xing_det u_xing (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .os_en_i (os_en_i),
    .din_i   (din_i),
    .xing_o  (xing)
  );

  bcr_mode_ctrl #(.MED_BITS(MED_BITS)) u_mode (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .acq_i       (acq_i),
    .track_i     (track_i),
    .sample_ev_i (sample_ev),
    .tmr_o       (tmr),
    .mode_o      (mode)
  );

  bcr_phase_loop #(
    .OS_TICKS (OS_TICKS),
    .MED_LIM  (MED_LIM),
    .NAR_LIM  (NAR_LIM)
  ) u_loop (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .os_en_i     (os_en_i),
    .xing_i      (xing),
    .mode_i      (mode),
    .cnt_o       (cnt),
    .err_o       (xing_err),
    .adj_o       (adj),
    .pair_done_o (pair_done)
  );

  assign sample_ev = os_en_i && (cnt == CNT_W'(HALF));
  assign rclk_o    = (cnt >= CNT_W'(HALF));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o     <= 1'b0;
      qual_good_o <= 1'b0;
      qual_stb_o  <= 1'b0;
    end else begin
      qual_stb_o <= xing;
      if (sample_ev) rdata_o <= din_i;
      if (xing) qual_good_o <= (abs_i(int'(xing_err)) <= GOOD_TOL);
    end
  end
endmodule

// File: rtl/bcr_chk.sv
module bcr_chk
  import bcr_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int ERR_W   = 8,
  parameter int TMR_W   = 5,
  parameter int MED_LIM = 4,
  parameter int NAR_LIM = 1
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    os_en_i,
  input logic                    acq_i,
  input logic                    xing,
  input logic                    sample_ev,
  input bcr_mode_e               mode,
  input logic [CNT_W-1:0]        cnt,
  input logic signed [ERR_W-1:0] adj,
  input logic [TMR_W-1:0]        tmr,
  input logic                    rdata_o,
  input logic                    qual_stb_o
);
  // R2
  hold_freerun_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (os_en_i && mode == MODE_HOLD) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !os_en_i |=> ($stable(cnt) && $stable(rdata_o) && !qual_stb_o));

  // R5
  med_clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == MODE_MED) |-> (int'(adj) <= MED_LIM && int'(adj) >= -MED_LIM));

  // R6
  nar_clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == MODE_NAR) |-> (int'(adj) <= NAR_LIM && int'(adj) >= -NAR_LIM));

  // R7
  tmr_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acq_i |=> (tmr == '0));

  // R8
  rdata_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(rdata_o) |-> $past(sample_ev));

  // R9
  qual_stb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    qual_stb_o |-> $past(xing));
endmodule

bind bit_clock_recovery bcr_chk #(
  .CNT_W   (CNT_W),
  .ERR_W   (ERR_W),
  .TMR_W   (TMR_W),
  .MED_LIM (MED_LIM),
  .NAR_LIM (NAR_LIM)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .os_en_i    (os_en_i),
  .acq_i      (acq_i),
  .xing       (xing),
  .sample_ev  (sample_ev),
  .mode       (mode),
  .cnt        (cnt),
  .adj        (adj),
  .tmr        (tmr),
  .rdata_o    (rdata_o),
  .qual_stb_o (qual_stb_o)
);

// File: tb/bit_clock_recovery_tb.sv
module bit_clock_recovery_tb;
  logic clk = 1'b0, rst = 1'b1, os_en = 1'b0, din = 1'b0, acq = 1'b0, trk = 1'b0;
  logic rclk, rdata, qgood, qstb;

  int checks = 0, errors = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  // reference model state
  int m_cnt, m_dinq, m_pair, m_err1, m_tmr, m_md;
  bit m_rdata, m_qgood, m_qstb;

  // transmitter
  int tx_ph = 29;
  logic [15:0] lfsr = 16'hACE1;
  bit tx_bit = 1'b0;

  // lock monitor
  int bad_seen = 0, good_seen = 0;

  always #5 clk = ~clk;

  bit_clock_recovery u_dut (
    .clk_i(clk), .rst_i(rst), .os_en_i(os_en), .din_i(din), .acq_i(acq), .track_i(trk),
    .rclk_o(rclk), .rdata_o(rdata), .qual_good_o(qgood), .qual_stb_o(qstb)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, updated on the same edges as the design
  always @(posedge clk) begin
    int e, s, adj, nxt;
    bit stb;
    if (rst) begin
      m_cnt = 0; m_dinq = 0; m_pair = 0; m_err1 = 0; m_tmr = 0;
      m_rdata = 0; m_qgood = 0; m_qstb = 0; m_md = 0;
    end else begin
      if (acq) m_md = 0;
      else if (!trk) m_md = 3;
      else if (m_tmr < 30) m_md = 1;
      else m_md = 2;
      stb = 0; adj = 0;
      if (os_en) begin
        e = (m_cnt >= 32) ? m_cnt - 64 : m_cnt;
        if (din != m_dinq) begin
          stb = 1;
          m_qgood = (e >= -8 && e <= 8);
          if (m_md != 3) begin
            if (m_pair == 0) begin m_err1 = e; m_pair = 1; end
            else begin
              s = m_err1 + e; m_pair = 0;
              if (m_md == 0) adj = (s < 0) ? -((1 - s) / 2) : s / 2;
              else if (m_md == 1) adj = (s > 4) ? 4 : ((s < -4) ? -4 : s);
              else adj = (s > 1) ? 1 : ((s < -1) ? -1 : s);
            end
          end
        end
        if (m_cnt == 32) begin
          m_rdata = din;
          if (!acq && m_tmr < 30) m_tmr++;
        end
        nxt = (m_cnt + 1 - adj) % 64;
        m_cnt = (nxt < 0) ? nxt + 64 : nxt;
        m_dinq = din;
      end
      if (m_md == 3) m_pair = 0;
      if (acq) m_tmr = 0;
      m_qstb = stb;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    string ctag;
    if (cmp_on && !rst) begin
      case (m_md)
        0: ctag = "R4 rclk(acquire)";
        1: ctag = "R5 R7 rclk(medium)";
        2: ctag = "R6 R7 rclk(narrow)";
        default: ctag = "R2 rclk(hold)";
      endcase
      chk(ctag, int'(rclk), int'(m_cnt >= 32));
      chk("R8 rdata", int'(rdata), int'(m_rdata));
      chk("R3 R9 qual_good", int'(qgood), int'(m_qgood));
      chk("R9 qual_stb", int'(qstb), int'(m_qstb));
      if (qstb && !qgood) bad_seen++;
      if (qstb && qgood) good_seen++;
    end
  end

  task automatic tick();
    @(negedge clk);
    tx_ph = (tx_ph + 1) % 64;
    if (tx_ph == 0) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_bit = lfsr[0];
    end
    din = tx_bit;
    os_en = 1'b1;
    @(negedge clk);
    os_en = 1'b0;
  endtask

  task automatic run_bits(int n);
    for (int i = 0; i < n * 64; i++) tick();
  endtask

  task automatic reset_check(string tag);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({tag, " rclk"}, int'(rclk), 0);
    chk({tag, " rdata"}, int'(rdata), 0);
    chk({tag, " qual_good"}, int'(qgood), 0);
    chk({tag, " qual_stb"}, int'(qstb), 0);
    rst = 1'b0;
  endtask

  initial begin
    bit s_rclk, s_rdata, s_qg;
    repeat (2) @(negedge clk);
    reset_check("R1 reset");
    cmp_on = 1'b1;

    // acquire from an arbitrary offset
    acq = 1'b1; trk = 1'b1;
    run_bits(6);
    bad_seen = 0; good_seen = 0;
    run_bits(14);
    chk("R4 lock bad grades", bad_seen, 0);
    chk("R4 lock graded crossings present", int'(good_seen > 4), 1);

    // release acquire, shift phase: medium clamp then narrow
    acq = 1'b0;
    tx_ph = (tx_ph + 12) % 64;
    run_bits(36);
    tx_ph = (tx_ph + 6) % 64;
    run_bits(30);
    bad_seen = 0;
    run_bits(10);
    chk("R6 narrow relock bad grades", bad_seen, 0);

    // hold: freewheel through a phase jump
    trk = 1'b0;
    tx_ph = (tx_ph + 20) % 64;
    run_bits(12);

    // gap in the enable with a busy input
    @(negedge clk);
    s_rclk = rclk; s_rdata = rdata; s_qg = qgood;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      din = ~din;
    end
    chk("R10 rclk frozen", int'(rclk), int'(s_rclk));
    chk("R10 rdata frozen", int'(rdata), int'(s_rdata));
    chk("R10 qual_good frozen", int'(qgood), int'(s_qg));
    chk("R10 no strobe", int'(qstb), 0);
    din = tx_bit;

    // reacquire, then reset in the middle of a run
    trk = 1'b1; acq = 1'b1;
    run_bits(8);
    acq = 1'b0;
    run_bits(6);
    cmp_on = 1'b0;
    reset_check("R1 mid-run reset");
    cmp_on = 1'b1;
    run_bits(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule